// File: doc/BRIEF.md
# Thermal Sensor Register Slave on a Two-Wire Management Bus

This block is a bus slave for the two-wire management bus (SMBus) that gives a host access to a small thermal sensor register set. It listens on the open-drain clock and data lines, which it oversamples with the system clock. It pulls the data line low to acknowledge or to send a zero, and otherwise leaves it released. Five transaction shapes are served: Write Byte, Read Byte, Send Byte, Receive Byte, and a query on the shared alert-response address. That query tells a host which device raised an alert.

The command byte of every write-direction transaction is kept as a register pointer. A register is read through one command code and written through a different one. The configuration and conversion rate bytes are writable. The high and low limits are fixed at their reset values. The temperature and status bytes come in on input ports from logic outside this block. An alert is latched from an input pulse. While it is pending, the slave answers the alert-response address with its own 7-bit address and then drops the alert.

Top module: `smbt_therm_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal its own address, or equal the alert-response address 0001100 with the read bit set while the alert is pending. It leaves SDA released in every other case.
- R2: Write Byte with command 09h stores the data byte in the configuration register, and with command 0Ah stores it in the conversion rate register. The slave acknowledges all three bytes.
- R3: Read Byte returns the byte selected by the command: 01h temperature input, 02h status input, 03h configuration, 04h conversion rate, 07h high limit, 08h low limit. The byte is sent most significant bit first.
- R4: After reset, configuration is 00h, conversion rate is 02h, high limit is 7Fh, low limit is C9h, the alert is clear and SDA is released.
- R5: A Write Byte whose command is any code other than 09h or 0Ah is fully acknowledged but changes no register.
- R6: Reading through any command code outside the six listed in R3 returns 00h.
- R7: Send Byte loads the command byte into the pointer. Receive Byte returns the byte that the pointer selects. The pointer is 01h after reset.
- R8: A read on the alert-response address while the alert is pending returns the slave's own 7-bit address in data bits 7 to 1.
- R9: A one-cycle alert request sets the pending alert. The alert clears when the master's acknowledge slot of an alert-response data byte ends. A request in that same cycle keeps the alert set.
- R10: A start or stop condition anywhere in a transaction abandons it. A data byte that was only partly received writes nothing, and a start begins a new address phase.
- R11: The slave changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| scl_in | input | 1 | Level of the bus clock line |
| sda_in | input | 1 | Level of the bus data line |
| sda_oe | output | 1 | 1 pulls the data line low |
| temp_in | input | 8 | Current temperature byte |
| status_in | input | 8 | Current status byte |
| alert_set | input | 1 | Request that raises the pending alert |
| alert_o | output | 1 | Pending alert flag |
| cfg_o | output | 8 | Configuration register |
| rate_o | output | 8 | Conversion rate register |

## Verification
Two functions can fall in the same clock cycle: the alert clear that follows an alert-response byte, and a fresh alert request. The bench holds the request input high for a whole alert-response transaction, so a request lands exactly on the clearing edge. It then expects the alert to still be pending after the stop, and a second query to succeed. A start condition is also placed in the middle of a data byte. The stored configuration must then stay unchanged, and the transaction that follows must decode normally.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 7;

  localparam logic [ADDR_W-1:0] ALERT_RESP_ADDR = 7'b0001100;

  localparam logic [BYTE_W-1:0] CMD_RD_TEMP   = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_RD_STATUS = 8'h02;
  localparam logic [BYTE_W-1:0] CMD_RD_CFG    = 8'h03;
  localparam logic [BYTE_W-1:0] CMD_RD_RATE   = 8'h04;
  localparam logic [BYTE_W-1:0] CMD_RD_HIGH   = 8'h07;
  localparam logic [BYTE_W-1:0] CMD_RD_LOW    = 8'h08;
  localparam logic [BYTE_W-1:0] CMD_WR_CFG    = 8'h09;
  localparam logic [BYTE_W-1:0] CMD_WR_RATE   = 8'h0A;

  localparam logic [BYTE_W-1:0] RST_CFG  = 8'h00;
  localparam logic [BYTE_W-1:0] RST_RATE = 8'h02;
  localparam logic [BYTE_W-1:0] LIM_HIGH = 8'h7F;
  localparam logic [BYTE_W-1:0] LIM_LOW  = 8'hC9;
  localparam logic [BYTE_W-1:0] RST_PTR  = CMD_RD_TEMP;

  typedef enum logic [3:0] {
    LS_IDLE,
    LS_ADDR,
    LS_AACK,
    LS_CMD,
    LS_CACK,
    LS_DATA,
    LS_DACK,
    LS_TX,
    LS_MACK,
    LS_SKIP
  } link_state_t;

endpackage

// File: rtl/smbt_line_sync.sv
module smbt_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe_q, scl_pipe_d;
  logic [STAGES-1:0] sda_pipe_q, sda_pipe_d;
  logic              scl_prev_q, sda_prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_comb begin
        scl_pipe_d = scl_in;
        sda_pipe_d = sda_in;
      end
    end else begin : g_chain
      always_comb begin
        scl_pipe_d = {scl_pipe_q[STAGES-2:0], scl_in};
        sda_pipe_d = {sda_pipe_q[STAGES-2:0], sda_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_prev_q <= scl_pipe_q[STAGES-1];
      sda_prev_q <= sda_pipe_q[STAGES-1];
    end
  end

  always_comb begin
    scl_lvl   = scl_pipe_q[STAGES-1];
    sda_lvl   = sda_pipe_q[STAGES-1];
    scl_rise  = scl_lvl & ~scl_prev_q;
    scl_fall  = ~scl_lvl & scl_prev_q;
    start_det = scl_lvl & scl_prev_q & sda_prev_q & ~sda_lvl;
    stop_det  = scl_lvl & scl_prev_q & ~sda_prev_q & sda_lvl;
  end

endmodule

// File: rtl/smbt_regs.sv
module smbt_regs
  import smbt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_ld,
  input  logic [BYTE_W-1:0] ptr_val,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] temp_in,
  input  logic [BYTE_W-1:0] status_in,
  input  logic              alert_set,
  input  logic              alert_clr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] ptr_q,
  output logic [BYTE_W-1:0] cfg_q,
  output logic [BYTE_W-1:0] rate_q,
  output logic              alert_q
);

  logic [BYTE_W-1:0] ptr_d, cfg_d, rate_d;
  logic              alert_d;
  logic              cfg_en, rate_en, ptr_en, alert_en;

  function automatic logic [BYTE_W-1:0] sel_byte(
    input logic [BYTE_W-1:0] code,
    input logic [BYTE_W-1:0] t,
    input logic [BYTE_W-1:0] s,
    input logic [BYTE_W-1:0] c,
    input logic [BYTE_W-1:0] r
  );
    case (code)
      CMD_RD_TEMP:   sel_byte = t;
      CMD_RD_STATUS: sel_byte = s;
      CMD_RD_CFG:    sel_byte = c;
      CMD_RD_RATE:   sel_byte = r;
      CMD_RD_HIGH:   sel_byte = LIM_HIGH;
      CMD_RD_LOW:    sel_byte = LIM_LOW;
      default:       sel_byte = '0;
    endcase
  endfunction

  always_comb begin
    ptr_en   = ptr_ld;
    ptr_d    = ptr_val;
    cfg_en   = wr_stb && (ptr_q == CMD_WR_CFG);
    rate_en  = wr_stb && (ptr_q == CMD_WR_RATE);
    cfg_d    = wr_data;
    rate_d   = wr_data;
    alert_en = alert_set | alert_clr;
    alert_d  = alert_set;
    rd_data  = sel_byte(ptr_q, temp_in, status_in, cfg_q, rate_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= RST_PTR;
      cfg_q   <= RST_CFG;
      rate_q  <= RST_RATE;
      alert_q <= 1'b0;
    end else begin
      if (ptr_en)   ptr_q   <= ptr_d;
      if (cfg_en)   cfg_q   <= cfg_d;
      if (rate_en)  rate_q  <= rate_d;
      if (alert_en) alert_q <= alert_d;
    end
  end

endmodule

// File: rtl/smbt_link.sv
module smbt_link
  import smbt_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              alert_q,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              ptr_ld,
  output logic [BYTE_W-1:0] ptr_val,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_data,
  output logic              ara_done
);

  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  link_state_t       st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              rw_q, rw_d;
  logic              ara_q, ara_d;
  logic              nack_q, nack_d;
  logic              own_hit, ara_hit;
  logic [BYTE_W-1:0] tx_byte;

  always_comb begin
    own_hit = (sh_q[BYTE_W-1:1] == DEV_ADDR);
    ara_hit = (sh_q[BYTE_W-1:1] == ALERT_RESP_ADDR) && sh_q[0] && alert_q;
    tx_byte = ara_q ? {DEV_ADDR, 1'b1} : rd_data;
  end

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    rw_d     = rw_q;
    ara_d    = ara_q;
    nack_d   = nack_q;
    ptr_ld   = 1'b0;
    ptr_val  = sh_q;
    wr_stb   = 1'b0;
    wr_data  = sh_q;
    ara_done = 1'b0;

    if (start_det) begin
      st_d  = LS_ADDR;
      cnt_d = '0;
      ara_d = 1'b0;
    end else if (stop_det) begin
      st_d  = LS_IDLE;
      ara_d = 1'b0;
    end else begin
      case (st_q)
        LS_ADDR, LS_CMD, LS_DATA: begin
          if (scl_rise && (cnt_q != CNT_FULL)) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && (cnt_q == CNT_FULL)) begin
            cnt_d = '0;
            if (st_q == LS_ADDR) begin
              if (own_hit || ara_hit) begin
                st_d  = LS_AACK;
                rw_d  = sh_q[0];
                ara_d = ara_hit;
              end else begin
                st_d = LS_SKIP;
              end
            end else if (st_q == LS_CMD) begin
              ptr_ld = 1'b1;
              st_d   = LS_CACK;
            end else begin
              wr_stb = 1'b1;
              st_d   = LS_DACK;
            end
          end
        end
        LS_AACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              sh_d = tx_byte;
              st_d = LS_TX;
            end else begin
              st_d = LS_CMD;
            end
          end
        end
        LS_CACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            st_d  = LS_DATA;
          end
        end
        LS_DACK: begin
          if (scl_fall) st_d = LS_SKIP;
        end
        LS_TX: begin
          if (scl_fall) begin
            sh_d = {sh_q[BYTE_W-2:0], 1'b1};
            if (cnt_q == CNT_LAST) begin
              cnt_d = '0;
              st_d  = LS_MACK;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        LS_MACK: begin
          if (scl_rise) begin
            nack_d = sda_lvl;
          end else if (scl_fall) begin
            ara_done = ara_q;
            if (!nack_q) begin
              sh_d = tx_byte;
              st_d = LS_TX;
            end else begin
              st_d = LS_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    sda_oe = (st_q == LS_AACK) || (st_q == LS_CACK) || (st_q == LS_DACK) ||
             ((st_q == LS_TX) && !sh_q[BYTE_W-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LS_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      rw_q   <= 1'b0;
      ara_q  <= 1'b0;
      nack_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      rw_q   <= rw_d;
      ara_q  <= ara_d;
      nack_q <= nack_d;
    end
  end

endmodule

// File: rtl/smbt_therm_slave.sv
module smbt_therm_slave
  import smbt_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h2A,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [BYTE_W-1:0] temp_in,
  input  logic [BYTE_W-1:0] status_in,
  input  logic              alert_set,
  output logic              alert_o,
  output logic [BYTE_W-1:0] cfg_o,
  output logic [BYTE_W-1:0] rate_o
);

  logic [1:0]        rst_pipe_q;
  logic              rst_q;
  logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic              ptr_ld, wr_stb, ara_done;
  logic [BYTE_W-1:0] ptr_val, wr_data, rd_data, ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q = rst_pipe_q[1];

  smbt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_q),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smbt_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk       (clk),
    .rst_n     (rst_q),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .alert_q   (alert_o),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .ptr_ld    (ptr_ld),
    .ptr_val   (ptr_val),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .ara_done  (ara_done)
  );

  smbt_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_q),
    .ptr_ld    (ptr_ld),
    .ptr_val   (ptr_val),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .temp_in   (temp_in),
    .status_in (status_in),
    .alert_set (alert_set),
    .alert_clr (ara_done),
    .rd_data   (rd_data),
    .ptr_q     (ptr_q),
    .cfg_q     (cfg_o),
    .rate_q    (rate_o),
    .alert_q   (alert_o)
  );

endmodule

// File: rtl/smbt_therm_checker.sv
module smbt_therm_checker
  import smbt_pkg::*;
(
  input logic              clk,
  input logic              rst_q,
  input logic              scl_lvl,
  input logic              stop_det,
  input logic              sda_oe,
  input logic              alert_set,
  input logic              alert_o,
  input logic              ara_done,
  input logic              wr_stb,
  input logic [BYTE_W-1:0] ptr_q,
  input logic [BYTE_W-1:0] cfg_o,
  input logic [BYTE_W-1:0] rate_o
);

  // R11: drive changes only while the synchronized clock line is low
  a_r11_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(sda_oe) |-> !scl_lvl);

  // R10: a stop leaves the data line released
  a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_q)
    stop_det |=> !sda_oe);

  // R9: a request always leaves the alert pending, even against a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_q)
    alert_set |=> alert_o);

  // R9: the alert only drops after an alert-response byte completes
  a_r9_clear_cause: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(alert_o) |-> $past(ara_done));

  // R2, R5: configuration changes only through its own write code
  a_r5_cfg_guard: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(cfg_o) |-> ($past(wr_stb) && ($past(ptr_q) == CMD_WR_CFG)));

  // R2, R5: conversion rate changes only through its own write code
  a_r5_rate_guard: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(rate_o) |-> ($past(wr_stb) && ($past(ptr_q) == CMD_WR_RATE)));

endmodule

bind smbt_therm_slave smbt_therm_checker u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .scl_lvl   (scl_lvl),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe),
  .alert_set (alert_set),
  .alert_o   (alert_o),
  .ara_done  (ara_done),
  .wr_stb    (wr_stb),
  .ptr_q     (ptr_q),
  .cfg_o     (cfg_o),
  .rate_o    (rate_o)
);

// File: tb/smbt_therm_slave_test.sv
module smbt_therm_slave_test;

  localparam logic [6:0] SLV = 7'h2A;
  localparam logic [6:0] ARA = 7'b0001100;
  localparam int Q = 6;

  logic       clk;
  logic       rst_n;
  logic       scl;
  logic       m_low;
  logic       sda_oe;
  logic [7:0] temp_in, status_in;
  logic       alert_set;
  logic       alert_o;
  logic [7:0] cfg_o, rate_o;
  logic       sda_bus;

  int n_chk;
  int n_bad;
  logic [7:0] cfg_m, rate_m;

  assign sda_bus = ~(m_low | sda_oe);

  smbt_therm_slave #(.DEV_ADDR(SLV)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl),
    .sda_in    (sda_bus),
    .sda_oe    (sda_oe),
    .temp_in   (temp_in),
    .status_in (status_in),
    .alert_set (alert_set),
    .alert_o   (alert_o),
    .cfg_o     (cfg_o),
    .rate_o    (rate_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] exp_read(input logic [7:0] code, input logic [7:0] t,
                                          input logic [7:0] s, input logic [7:0] c,
                                          input logic [7:0] r);
    case (code)
      8'h01: return t;
      8'h02: return s;
      8'h03: return c;
      8'h04: return r;
      8'h07: return 8'h7F;
      8'h08: return 8'hC9;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    m_low = 1'b1; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    m_low = 1'b0; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    m_low = ~b; tick(Q);
    scl = 1'b1; tick(2*Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    m_low = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    b = sda_bus;  tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic get_byte(output logic [7:0] v, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(nack);
  endtask

  task automatic wr_byte(input logic [7:0] cmd, input logic [7:0] d, output logic ok);
    logic a1, a2, a3;
    bus_start();
    put_byte({SLV, 1'b0}, a1);
    put_byte(cmd, a2);
    put_byte(d, a3);
    bus_stop();
    ok = a1 & a2 & a3;
  endtask

  task automatic rd_byte(input logic [7:0] cmd, output logic [7:0] d, output logic ok);
    logic a1, a2, a3;
    bus_start();
    put_byte({SLV, 1'b0}, a1);
    put_byte(cmd, a2);
    bus_start();
    put_byte({SLV, 1'b1}, a3);
    get_byte(d, 1'b1);
    bus_stop();
    ok = a1 & a2 & a3;
  endtask

  task automatic send_byte(input logic [7:0] cmd, output logic ok);
    logic a1, a2;
    bus_start();
    put_byte({SLV, 1'b0}, a1);
    put_byte(cmd, a2);
    bus_stop();
    ok = a1 & a2;
  endtask

  task automatic recv_byte(input logic [6:0] addr, output logic [7:0] d, output logic ok);
    logic a1;
    bus_start();
    put_byte({addr, 1'b1}, a1);
    d = 8'hFF;
    if (a1) get_byte(d, 1'b1);
    bus_stop();
    ok = a1;
  endtask

  task automatic pulse_alert();
    alert_set = 1'b1; tick(1);
    alert_set = 1'b0; tick(1);
  endtask

  initial begin
    logic       ok;
    logic [7:0] d;
    n_chk = 0; n_bad = 0;
    void'($urandom(32'd1234));
    rst_n = 1'b0; scl = 1'b1; m_low = 1'b0;
    temp_in = 8'h19; status_in = 8'h00; alert_set = 1'b0;
    cfg_m = 8'h00; rate_m = 8'h02;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R4: reset state at the ports
    chk("R4", "cfg after reset", cfg_o, 8'h00);
    chk("R4", "rate after reset", rate_o, 8'h02);
    chk("R4", "alert after reset", {7'd0, alert_o}, 8'h00);
    chk("R4", "sda drive after reset", {7'd0, sda_oe}, 8'h00);

    // R7: pointer is the temperature code after reset
    temp_in = 8'h3C;
    recv_byte(SLV, d, ok);
    chk("R7", "receive ack", {7'd0, ok}, 8'h01);
    chk("R7", "receive after reset", d, 8'h3C);

    // R4, R3: limits and reset registers through Read Byte
    rd_byte(8'h07, d, ok);
    chk("R4", "high limit", d, 8'h7F);
    rd_byte(8'h08, d, ok);
    chk("R4", "low limit", d, 8'hC9);
    rd_byte(8'h04, d, ok);
    chk("R3", "rate read", d, 8'h02);

    // R1: foreign address is not acknowledged
    recv_byte(SLV ^ 7'h01, d, ok);
    chk("R1", "foreign address ack", {7'd0, ok}, 8'h00);
    // R1: alert-response address with no alert pending
    recv_byte(ARA, d, ok);
    chk("R1", "idle alert query ack", {7'd0, ok}, 8'h00);

    // R2: configuration write and read-back
    wr_byte(8'h09, 8'hA5, ok);
    cfg_m = 8'hA5;
    chk("R2", "write cfg acks", {7'd0, ok}, 8'h01);
    chk("R2", "cfg port", cfg_o, cfg_m);
    rd_byte(8'h03, d, ok);
    chk("R3", "cfg read", d, cfg_m);

    // R5: writes via read-only and reserved codes change nothing
    wr_byte(8'h03, 8'h11, ok);
    chk("R5", "read code write acks", {7'd0, ok}, 8'h01);
    chk("R5", "cfg after read-code write", cfg_o, cfg_m);
    wr_byte(8'h05, 8'h22, ok);
    chk("R5", "reserved write acks", {7'd0, ok}, 8'h01);
    chk("R5", "cfg after reserved write", cfg_o, cfg_m);
    chk("R5", "rate after reserved write", rate_o, rate_m);

    // R6: reserved and write codes read as zero
    rd_byte(8'h00, d, ok);  chk("R6", "read 00h", d, 8'h00);
    rd_byte(8'h05, d, ok);  chk("R6", "read 05h", d, 8'h00);
    rd_byte(8'h0B, d, ok);  chk("R6", "read 0Bh", d, 8'h00);
    rd_byte(8'h09, d, ok);  chk("R6", "read 09h", d, 8'h00);

    // R7: Send Byte then Receive Byte
    status_in = 8'h81;
    send_byte(8'h02, ok);
    chk("R7", "send ack", {7'd0, ok}, 8'h01);
    recv_byte(SLV, d, ok);
    chk("R7", "receive status", d, 8'h81);

    // R10: start in the middle of a data byte abandons the write
    bus_start();
    put_byte({SLV, 1'b0}, ok);
    put_byte(8'h09, ok);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_start();
    put_byte({SLV, 1'b1}, ok);
    chk("R10", "restart address ack", {7'd0, ok}, 8'h01);
    get_byte(d, 1'b1);
    bus_stop();
    chk("R10", "read after restart", d, 8'h00);
    chk("R10", "cfg after aborted write", cfg_o, cfg_m);
    // R10: stop mid byte
    bus_start();
    put_byte({SLV, 1'b0}, ok);
    put_byte(8'h0A, ok);
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    bus_stop();
    chk("R10", "rate after stop abort", rate_o, rate_m);

    // R8, R9: alert query
    pulse_alert();
    chk("R9", "alert latched", {7'd0, alert_o}, 8'h01);
    recv_byte(ARA, d, ok);
    chk("R8", "alert query ack", {7'd0, ok}, 8'h01);
    chk("R8", "alert query address", {1'b0, d[7:1]}, {1'b0, SLV});
    chk("R9", "alert cleared", {7'd0, alert_o}, 8'h00);

    // R9: request held across the clearing cycle keeps the alert
    alert_set = 1'b1;
    recv_byte(ARA, d, ok);
    alert_set = 1'b0;
    tick(2);
    chk("R9", "alert kept by coincident request", {7'd0, alert_o}, 8'h01);
    recv_byte(ARA, d, ok);
    chk("R8", "second query address", {1'b0, d[7:1]}, {1'b0, SLV});
    chk("R9", "alert cleared again", {7'd0, alert_o}, 8'h00);

    // R2, R3: constrained random traffic
    for (int it = 0; it < 30; it++) begin
      int op;
      logic [7:0] v;
      op = $urandom_range(0, 3);
      v = 8'($urandom());
      case (op)
        0: begin
          wr_byte(8'h09, v, ok); cfg_m = v;
          chk("R2", "rand cfg port", cfg_o, cfg_m);
        end
        1: begin
          wr_byte(8'h0A, v, ok); rate_m = v;
          chk("R2", "rand rate port", rate_o, rate_m);
        end
        2: begin
          temp_in = v;
          rd_byte(8'h01, d, ok);
          chk("R3", "rand temp read", d, exp_read(8'h01, temp_in, status_in, cfg_m, rate_m));
        end
        default: begin
          logic [7:0] c;
          c = 8'($urandom_range(0, 11));
          status_in = v;
          rd_byte(c, d, ok);
          chk("R3", "rand code read", d, exp_read(c, temp_in, status_in, cfg_m, rate_m));
        end
      endcase
      chk("R1", "rand ack", {7'd0, ok}, 8'h01);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule